// File: doc/BRIEF.md
# Serial Configuration Register Interface

This block is a write-only three-wire serial slave. It loads 16-bit configuration words into four registers and drives their decoded fields as outputs to the rest of an analog front end. A host lowers chip-select, sends sixteen data bits, one on each rising serial-clock edge, and raises chip-select again. The bit sent first is bit 0 of the word. Bits 0 to 2 carry the register address and bits 3 to 15 carry the payload.

Chip-select, serial clock and serial data are all resynchronised into the conversion clock domain. Clock edges and the end of a frame are then detected by sampling in that domain. A frame is written into its register when chip-select rises, and only when exactly sixteen serial clocks arrived in the frame. Frames addressed to locations 4 to 7 are dropped. Register 2 contains an active-low software reset bit. When a frame releases that bit, meaning it goes from 0 to 1, the block emits a one-cycle launch pulse. The pulse starts an offset-calibration timer that holds a busy flag for a fixed number of conversion clocks (40000 by default) and then raises a done flag.

Top module: `cfg_serial_if`

## Requirements
- R1: After reset all decoded fields are 0, except `clamp_code`, which is 9. `soft_rst_n`, `cal_start`, `cal_busy` and `cal_done` are 0.
- R2: A 16-bit frame is taken least-significant bit first on serial-clock rising edges while `cs_n` is low, and is committed when `cs_n` rises. Bits 2..0 are the address. Register 0 drives `gain_code` from bits 12..3 and `in_sel` from bit 15.
- R3: Register 1 drives `sleep` from bit 3, `standby` from bit 4, `out_mode` from bits 7..5 and `filt_sel` from bits 13..8.
- R4: Register 2 drives `clamp_code` from bits 7..3, `settle_time` from bits 9..8, `settle_mult` from bits 11..10, `low_power` from bit 12, `pulse_inv` from bit 13 and `soft_rst_n` from bit 15.
- R5: Register 3 drives `bias_off` from bit 3, `enc_mode` from bits 5..4, `avg4` from bit 6 and `ref_ctl` from bits 9..7.
- R6: A frame that delivers fewer or more than 16 serial clocks before `cs_n` rises changes no output.
- R7: A frame addressed to 4, 5, 6 or 7 changes no output.
- R8: A committed frame changes only the fields of the register it addresses.
- R9: `cal_start` pulses for exactly one cycle when a committed register 2 frame carries bit 15 = 1 while `soft_rst_n` is 0. A frame that keeps the bit at 1, or clears it to 0, gives no pulse.
- R10: After `cal_start`, `cal_busy` is high for exactly CAL_CYCLES cycles and `cal_done` is 0 during that time. `cal_done` rises in the cycle `cal_busy` falls and stays high until the next launch.
- R11: A launch that arrives while the timer is running restarts the count, so `cal_busy` stays high for a full CAL_CYCLES cycles after the latest pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sck | input | 1 | Serial clock, sampled on rising edges |
| sdi | input | 1 | Serial data, least-significant bit first |
| gain_code | output | 10 | Register 0 gain code |
| in_sel | output | 1 | Register 0 input select |
| sleep | output | 1 | Register 1 sleep request |
| standby | output | 1 | Register 1 standby request |
| out_mode | output | 3 | Register 1 output-mode bits |
| filt_sel | output | 6 | Register 1 filter selects |
| clamp_code | output | 5 | Register 2 black-clamp code |
| settle_time | output | 2 | Register 2 fast-settle cancel time |
| settle_mult | output | 2 | Register 2 fast-settle multiplier |
| low_power | output | 1 | Register 2 low-power select |
| pulse_inv | output | 1 | Register 2 sample-pulse inversion |
| soft_rst_n | output | 1 | Register 2 software reset, active low |
| bias_off | output | 1 | Register 3 center-bias disable |
| enc_mode | output | 2 | Register 3 gray/differential encoding mode |
| avg4 | output | 1 | Register 3 four-line average enable |
| ref_ctl | output | 3 | Register 3 reference-insertion controls |
| cal_start | output | 1 | One-cycle pulse when calibration is launched |
| cal_busy | output | 1 | Calibration timer running |
| cal_done | output | 1 | Calibration finished |

## Verification
Two events can fall on the same cycle: a new calibration launch and a countdown step of a timer that is already running. The launch must win, and it must not let the timer finish in between. The bench provokes this by releasing the reset bit, clearing it and releasing it again about 5000 cycles into a run. It then judges the result by whether `cal_busy` was still high when the second pulse arrived, by the length of the busy run measured from that second pulse, and by `cal_done` staying low until that run ends.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 3;
  localparam int NUM_REGS   = 4;
  localparam int RST_REG    = 2;
  localparam int RST_BIT    = 15;
  localparam int CLAMP_LSB  = 3;

  typedef logic [FRAME_BITS-1:0] frame_t;
  typedef logic [ADDR_W-1:0]     addr_t;

  function automatic addr_t frame_addr(frame_t w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic addr_live(addr_t a);
    return 32'(a) < NUM_REGS;
  endfunction

  function automatic frame_t reset_word(int idx, logic [4:0] clamp);
    frame_t w;
    w = '0;
    if (idx == RST_REG) w[CLAMP_LSB +: 5] = clamp;
    return w;
  endfunction

  function automatic logic is_release(frame_t w, frame_t cur);
    return w[RST_BIT] && !cur[RST_BIT];
  endfunction
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgs_shifter.sv
module cfgs_shifter
  import cfgs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_s,
  input  logic   sck_s,
  input  logic   sdi_s,
  output frame_t word,
  output logic   commit
);
  localparam int CNT_MAX = FRAME_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             cs_q, sck_q;
  logic [CNT_W-1:0] cnt;
  logic             cs_rise, sck_rise;

  assign cs_rise  = cs_s & ~cs_q;
  assign sck_rise = sck_s & ~sck_q & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
      cnt   <= '0;
      word  <= '0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
      if (cs_s) begin
        cnt <= '0;
      end else if (sck_rise) begin
        word <= {sdi_s, word[FRAME_BITS-1:1]};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end

  assign commit = cs_rise && (cnt == CNT_W'(FRAME_BITS));
endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile
  import cfgs_pkg::*;
#(
  parameter logic [4:0] CLAMP_RESET = 5'd9
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  commit,
  input  frame_t                                word,
  output logic [NUM_REGS-1:0][FRAME_BITS-1:0]   regs,
  output logic                                  release_pulse
);
  addr_t wa;
  assign wa = frame_addr(word);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= reset_word(g, CLAMP_RESET);
      else if (commit && addr_live(wa) && wa == ADDR_W'(g)) regs[g] <= word;
    end
  end

  assign release_pulse = commit && wa == ADDR_W'(RST_REG) && is_release(word, regs[RST_REG]);
endmodule

// File: rtl/cfgs_caltimer.sv
module cfgs_caltimer #(
  parameter int CAL_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (start) begin
      cnt  <= CW'(CAL_CYCLES);
      done <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) done <= 1'b1;
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/cfg_serial_if.sv
module cfg_serial_if
  import cfgs_pkg::*;
#(
  parameter int         CAL_CYCLES  = 40000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] CLAMP_RESET = 5'd9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  output logic [9:0] gain_code,
  output logic       in_sel,
  output logic       sleep,
  output logic       standby,
  output logic [2:0] out_mode,
  output logic [5:0] filt_sel,
  output logic [4:0] clamp_code,
  output logic [1:0] settle_time,
  output logic [1:0] settle_mult,
  output logic       low_power,
  output logic       pulse_inv,
  output logic       soft_rst_n,
  output logic       bias_off,
  output logic [1:0] enc_mode,
  output logic       avg4,
  output logic [2:0] ref_ctl,
  output logic       cal_start,
  output logic       cal_busy,
  output logic       cal_done
);
  logic [2:0] pins_s;
  frame_t     frame_word;
  logic       frame_commit;
  logic [NUM_REGS-1:0][FRAME_BITS-1:0] regs;

  cfgs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, sdi}), .q(pins_s)
  );

  cfgs_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_s(pins_s[2]), .sck_s(pins_s[1]), .sdi_s(pins_s[0]),
    .word(frame_word), .commit(frame_commit)
  );

  cfgs_regfile #(.CLAMP_RESET(CLAMP_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(frame_commit), .word(frame_word),
    .regs(regs), .release_pulse(cal_start)
  );

  cfgs_caltimer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk(clk), .rst_n(rst_n), .start(cal_start), .busy(cal_busy), .done(cal_done)
  );

  assign gain_code   = regs[0][12:3];
  assign in_sel      = regs[0][15];
  assign sleep       = regs[1][3];
  assign standby     = regs[1][4];
  assign out_mode    = regs[1][7:5];
  assign filt_sel    = regs[1][13:8];
  assign clamp_code  = regs[2][7:3];
  assign settle_time = regs[2][9:8];
  assign settle_mult = regs[2][11:10];
  assign low_power   = regs[2][12];
  assign pulse_inv   = regs[2][13];
  assign soft_rst_n  = regs[2][RST_BIT];
  assign bias_off    = regs[3][3];
  assign enc_mode    = regs[3][5:4];
  assign avg4        = regs[3][6];
  assign ref_ctl     = regs[3][9:7];
endmodule

module cfg_serial_if_chk #(
  parameter int CAL_CYCLES = 40000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       commit,
  input logic [2:0] wr_addr,
  input logic [9:0] gain_code,
  input logic [4:0] clamp_code,
  input logic       soft_rst_n,
  input logic       cal_start,
  input logic       cal_busy,
  input logic       cal_done
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (cal_start) run_len <= 0;
    else if (cal_busy) run_len <= run_len + 1;
  end

  // R9
  a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);
  a_r9_start_from_reset: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> !soft_rst_n);
  a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> soft_rst_n);
  // R10
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (cal_busy && !cal_done));
  a_r10_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> cal_done);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_busy && cal_done));
  a_r10_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> run_len == CAL_CYCLES);
  // R8
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(gain_code) && $stable(clamp_code) && $stable(soft_rst_n)));
  // R7
  a_r7_test_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_addr[2]) |=> ($stable(gain_code) && $stable(clamp_code) && $stable(soft_rst_n)));
endmodule

bind cfg_serial_if cfg_serial_if_chk #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(frame_commit), .wr_addr(frame_word[2:0]),
  .gain_code(gain_code), .clamp_code(clamp_code), .soft_rst_n(soft_rst_n),
  .cal_start(cal_start), .cal_busy(cal_busy), .cal_done(cal_done)
);

// File: tb/sim_cfg_serial_if.sv
module sim_cfg_serial_if;
  localparam int CAL = 40000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [9:0] gain_code; logic in_sel, sleep, standby;
  logic [2:0] out_mode; logic [5:0] filt_sel; logic [4:0] clamp_code;
  logic [1:0] settle_time, settle_mult; logic low_power, pulse_inv, soft_rst_n;
  logic bias_off; logic [1:0] enc_mode; logic avg4; logic [2:0] ref_ctl;
  logic cal_start, cal_busy, cal_done;

  always #2.5 clk = ~clk;

  cfg_serial_if #(.CAL_CYCLES(CAL)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .gain_code(gain_code), .in_sel(in_sel), .sleep(sleep), .standby(standby),
    .out_mode(out_mode), .filt_sel(filt_sel), .clamp_code(clamp_code),
    .settle_time(settle_time), .settle_mult(settle_mult), .low_power(low_power),
    .pulse_inv(pulse_inv), .soft_rst_n(soft_rst_n), .bias_off(bias_off),
    .enc_mode(enc_mode), .avg4(avg4), .ref_ctl(ref_ctl),
    .cal_start(cal_start), .cal_busy(cal_busy), .cal_done(cal_done)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [15:0] m [4];
  int exp_starts = 0;

  int starts = 0, run = 0, last_run = 0;
  bit prev_busy = 0, busy_at_start = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cal_start) begin
        starts <= starts + 1; run <= 0; busy_at_start <= cal_busy;
      end else if (cal_busy) run <= run + 1;
      if (prev_busy && !cal_busy) last_run <= run;
      prev_busy <= cal_busy;
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_fields(input string ctx);
    cmp({"R2 ", ctx}, "gain_code", 32'(gain_code), 32'(m[0][12:3]));
    cmp({"R2 ", ctx}, "in_sel", 32'(in_sel), 32'(m[0][15]));
    cmp({"R3 ", ctx}, "sleep", 32'(sleep), 32'(m[1][3]));
    cmp({"R3 ", ctx}, "standby", 32'(standby), 32'(m[1][4]));
    cmp({"R3 ", ctx}, "out_mode", 32'(out_mode), 32'(m[1][7:5]));
    cmp({"R3 ", ctx}, "filt_sel", 32'(filt_sel), 32'(m[1][13:8]));
    cmp({"R4 ", ctx}, "clamp_code", 32'(clamp_code), 32'(m[2][7:3]));
    cmp({"R4 ", ctx}, "settle_time", 32'(settle_time), 32'(m[2][9:8]));
    cmp({"R4 ", ctx}, "settle_mult", 32'(settle_mult), 32'(m[2][11:10]));
    cmp({"R4 ", ctx}, "low_power", 32'(low_power), 32'(m[2][12]));
    cmp({"R4 ", ctx}, "pulse_inv", 32'(pulse_inv), 32'(m[2][13]));
    cmp({"R4 ", ctx}, "soft_rst_n", 32'(soft_rst_n), 32'(m[2][15]));
    cmp({"R5 ", ctx}, "bias_off", 32'(bias_off), 32'(m[3][3]));
    cmp({"R5 ", ctx}, "enc_mode", 32'(enc_mode), 32'(m[3][5:4]));
    cmp({"R5 ", ctx}, "avg4", 32'(avg4), 32'(m[3][6]));
    cmp({"R5 ", ctx}, "ref_ctl", 32'(ref_ctl), 32'(m[3][9:7]));
  endtask

  task automatic send_frame(input logic [15:0] w, input int nclk);
    @(negedge clk); cs_n = 1'b0; repeat (2) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? w[i[3:0]] : 1'b0;
      repeat (2) @(negedge clk); sck = 1'b1;
      repeat (2) @(negedge clk); sck = 1'b0;
    end
    repeat (2) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
    if (nclk == 16 && w[2:0] < 3'd4) begin
      if (w[2:0] == 3'd2 && w[15] && !m[2][15]) exp_starts++;
      m[w[2:0]] = w;
    end
  endtask

  task automatic wait_idle();
    while (cal_busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] reg2_word(input logic rel, input logic [12:0] pay);
    logic [15:0] w;
    w = {pay, 3'd2};
    w[15] = rel;
    return w;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    m[0] = 16'h0; m[1] = 16'h0; m[2] = 16'h0048; m[3] = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check_fields("R1");
    cmp("R1", "clamp_code reset", 32'(clamp_code), 9);
    cmp("R1", "cal_busy", 32'(cal_busy), 0);
    cmp("R1", "cal_done", 32'(cal_done), 0);
    cmp("R1", "cal_start", 32'(cal_start), 0);

    // directed: one frame per register
    send_frame(16'b1010_1100_1101_0000, 16); check_fields("R8");
    send_frame(16'b0011_1010_1010_1001, 16); check_fields("R8");
    send_frame(16'b0000_0011_0110_1011, 16); check_fields("R8");
    send_frame(reg2_word(1'b0, 13'h1ABC), 16); check_fields("R8");

    // random mix of live registers, test addresses and bad lengths
    for (int k = 0; k < 150; k++) begin
      logic [15:0] w;
      int nclk;
      int sel;
      w = 16'($urandom);
      sel = int'($urandom_range(0, 6));
      case (sel)
        0: w[2:0] = 3'd0;
        1: w[2:0] = 3'd1;
        2: w[2:0] = 3'd3;
        default: w[2:0] = 3'(4 + (sel - 3) % 4);
      endcase
      if (sel == 6) w[2:0] = 3'(4 + int'($urandom_range(0, 3)));
      nclk = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 20)) : 16;
      send_frame(w, nclk);
      if (nclk != 16) check_fields("R6");
      else if (w[2]) check_fields("R7");
      else check_fields("R8");
    end
    // directed length corners
    send_frame(16'hFFF8, 15); check_fields("R6");
    send_frame(16'hFFF8, 17); check_fields("R6");
    send_frame(16'hFFFC, 16); check_fields("R7");
    cmp("R9", "no launch from other regs", starts, exp_starts);

    // R9 / R10: release launches calibration
    send_frame(reg2_word(1'b1, 13'h0155), 16); check_fields("R9");
    cmp("R9", "start count after release", starts, exp_starts);
    cmp("R10", "busy during run", 32'(cal_busy), 1);
    cmp("R10", "done low during run", 32'(cal_done), 0);
    wait_idle();
    cmp("R10", "busy run length", last_run, CAL);
    cmp("R10", "done after run", 32'(cal_done), 1);
    send_frame(reg2_word(1'b1, 13'h0AAA), 16); check_fields("R9");
    cmp("R9", "no launch 1 to 1", starts, exp_starts);
    cmp("R10", "done held", 32'(cal_done), 1);
    send_frame(reg2_word(1'b0, 13'h0AAA), 16); check_fields("R9");
    cmp("R9", "no launch 1 to 0", starts, exp_starts);

    // R11: relaunch while running
    send_frame(reg2_word(1'b1, 13'h0011), 16);
    repeat (5000) @(negedge clk);
    send_frame(reg2_word(1'b0, 13'h0011), 16);
    send_frame(reg2_word(1'b1, 13'h0011), 16);
    cmp("R11", "start count", starts, exp_starts);
    cmp("R11", "busy at relaunch", 32'(busy_at_start), 1);
    cmp("R11", "done low after relaunch", 32'(cal_done), 0);
    wait_idle();
    cmp("R11", "run length from relaunch", last_run, CAL);
    cmp("R10", "done after relaunch run", 32'(cal_done), 1);
    check_fields("R4");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule